// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencing Controller

This block is the control engine that sits beside an SRAM array backed by nonvolatile cells. It decides when the contents move in either direction and paces each move. A copy into the nonvolatile cells (a store) has two phases: the old nonvolatile data is erased, then it is programmed from the SRAM. A copy back into the SRAM (a recall) also has two phases: the SRAM is cleared, then the nonvolatile data is transferred in. Each phase is timed by a cycle counter, and the length of each phase is a parameter.

A store can be requested in three ways: by a software sequence detector, by an external agent that holds a shared open-drain busy line low, or by loss of power-good. A recall can be requested by the software detector or by power-good rising. Store requests from the busy line and from power loss are honoured only when the SRAM has been written since the last completed store. The block gates SRAM access and pulls the busy line low for the whole of every store. After any store, whether performed or skipped, it keeps the SRAM locked until the shared line reads high again.

The busy line is modelled as a wired-AND with a pull-up. It is pulled low by the block's own drive or by an external drive. A strong external driver that holds it high can override both.

Top module: `nvseq_ctrl`

## Requirements
- R1: While reset is asserted, and after reset while power-good is low, sramInhibit is 1. busyDriveLow, eraseOn, progOn, clearOn and xferOn are all 0, and busyLine reads 1.
- R2: When power-good is high in the off state (power-up), a recall runs: clearOn for CLEAR_CYC cycles, then xferOn for XFER_CYC cycles. sramInhibit stays 1 throughout and falls when the recall ends. eraseOn and progOn stay 0 during a recall.
- R3: A one-cycle swStoreReq in the ready state starts a store whether or not a write has happened: eraseOn for ERASE_CYC cycles, then progOn for PROG_CYC cycles. busyDriveLow is 1 in every cycle of both phases and in no other cycle of a software store.
- R4: A one-cycle swRecallReq in the ready state runs the same recall as R2 and does not drive the busy line.
- R5: A store requested through the busy line or by power loss runs only if at least one write was accepted since the last completed store. Otherwise no erase or program phase occurs.
- R6: The busy line counts as a store request only after it reads low for ASSERT_CYC consecutive cycles in the ready state. A low pulse of ASSERT_CYC-1 cycles has no effect.
- R7: After a busy-line request with the write flag set, the SRAM stays enabled (sramInhibit 0) for DELAY_CYC more cycles, and then eraseOn rises. The erase appears DELAY_CYC cycles after the ASSERT_CYC-th low cycle. An sramActivity or sramWrite pulse in that window starts the erase in the next cycle, and a write in the window is not accepted.
- R8: After a busy-line store ends, or right after a busy-line request is skipped, sramInhibit stays 1 while busyLine reads 0. It falls in the cycle after the line reads 1.
- R9: Loss of power-good in the ready state with the write flag clear sets sramInhibit without driving the busy line. While power is low, holding the busy line low starts no store.
- R10: On loss of power-good with the write flag set, busyDriveLow is asserted for one probe cycle. If busyLine reads 0, the full store follows. If busyLine reads 1 (forced high), the store is abandoned: busyDriveLow falls and no erase occurs.
- R11: writeAccept equals sramWrite in the ready state and is 0 in every other state. An accepted write sets the write flag, and a completed store clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwrGood | input | 1 | Supply above the switching threshold |
| swStoreReq | input | 1 | One-cycle software store request |
| swRecallReq | input | 1 | One-cycle software recall request |
| sramWrite | input | 1 | SRAM write attempt this cycle |
| sramActivity | input | 1 | Address or control transition this cycle |
| busyExtLow | input | 1 | External agent pulls the busy line low |
| busyForceHigh | input | 1 | Strong external driver holds the busy line high |
| sramInhibit | output | 1 | SRAM access disabled |
| writeAccept | output | 1 | Write attempt accepted into the SRAM |
| busyDriveLow | output | 1 | Block's own pull-down on the busy line |
| busyLine | output | 1 | Resolved level of the busy line |
| eraseOn | output | 1 | Store erase phase active |
| progOn | output | 1 | Store program phase active |
| clearOn | output | 1 | Recall clear phase active |
| xferOn | output | 1 | Recall transfer phase active |

## Verification
The bench builds the block with ERASE_CYC=6, PROG_CYC=10, CLEAR_CYC=3, XFER_CYC=4, ASSERT_CYC=4 and DELAY_CYC=8. With these values every phase length and the full assert-plus-delay window can be counted cycle by cycle in a few dozen clocks, so an off-by-one in any timer shows up as a wrong count. Short phases also let one run chain a power-up recall, software and busy-line stores, a skipped store, a cut-short delay window, and performed, skipped and abandoned power-fail stores.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;

  typedef enum logic [3:0] {
    S_OFF,
    S_RCL_CLR,
    S_RCL_XFER,
    S_READY,
    S_HW_WAIT,
    S_PF_PROBE,
    S_ST_ERASE,
    S_ST_PROG,
    S_HOLD
  } seqState_e;

  typedef enum logic [2:0] {
    PH_ERASE,
    PH_PROG,
    PH_CLEAR,
    PH_XFER,
    PH_DELAY
  } phase_e;

  typedef struct packed {
    logic   tmrLoad;
    phase_e tmrPhase;
    logic   cntEn;
    logic   dirtyClr;
    logic   writeOk;
  } ctrlStrobes_t;

  typedef struct packed {
    logic tmrDone;
    logic hwReq;
    logic dirty;
    logic lineHigh;
  } dpStatus_t;

endpackage

// File: rtl/nvseq_dp.sv
module nvseq_dp
  import nvseq_pkg::*;
#(
  parameter int ERASE_CYC  = 2000,
  parameter int PROG_CYC   = 8000,
  parameter int CLEAR_CYC  = 20,
  parameter int XFER_CYC   = 40,
  parameter int ASSERT_CYC = 50,
  parameter int DELAY_CYC  = 100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ctrlStrobes_t ctrl,
  input  logic         sramWrite,
  input  logic         busyDriveLow,
  input  logic         busyExtLow,
  input  logic         busyForceHigh,
  output dpStatus_t    status,
  output logic         writeAccept,
  output logic         busyLine
);

  localparam int M_ST   = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int M_RC   = (CLEAR_CYC > XFER_CYC) ? CLEAR_CYC : XFER_CYC;
  localparam int M_AB   = (M_ST > M_RC) ? M_ST : M_RC;
  localparam int M_ALL  = (M_AB > DELAY_CYC) ? M_AB : DELAY_CYC;
  localparam int TMR_W  = $clog2(M_ALL + 1);
  localparam int ACNT_W = $clog2(ASSERT_CYC + 1);

  logic [TMR_W-1:0]  tmr, loadVal;
  logic [ACNT_W-1:0] acnt;
  logic              dirty;

  // shared open-drain line: pull-up, two pull-downs, optional strong high
  assign busyLine    = busyForceHigh | ~(busyDriveLow | busyExtLow);
  assign writeAccept = sramWrite & ctrl.writeOk;

  always_comb begin
    case (ctrl.tmrPhase)
      PH_ERASE: loadVal = TMR_W'(ERASE_CYC - 1);
      PH_PROG:  loadVal = TMR_W'(PROG_CYC - 1);
      PH_CLEAR: loadVal = TMR_W'(CLEAR_CYC - 1);
      PH_XFER:  loadVal = TMR_W'(XFER_CYC - 1);
      PH_DELAY: loadVal = TMR_W'(DELAY_CYC - 1);
      default:  loadVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             tmr <= '0;
    else if (ctrl.tmrLoad)  tmr <= loadVal;
    else if (tmr != '0)     tmr <= tmr - 1'b1;
  end

  // consecutive-low counter for the hardware store request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           acnt <= '0;
    else if (!ctrl.cntEn || busyLine)     acnt <= '0;
    else if (acnt != ACNT_W'(ASSERT_CYC - 1)) acnt <= acnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             dirty <= 1'b0;
    else if (ctrl.dirtyClr) dirty <= 1'b0;
    else if (writeAccept)   dirty <= 1'b1;
  end

  assign status.tmrDone  = (tmr == '0);
  assign status.hwReq    = ctrl.cntEn && !busyLine && (acnt == ACNT_W'(ASSERT_CYC - 1));
  assign status.dirty    = dirty;
  assign status.lineHigh = busyLine;

endmodule

// File: rtl/nvseq_fsm.sv
module nvseq_fsm
  import nvseq_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pwrGood,
  input  logic         swStoreReq,
  input  logic         swRecallReq,
  input  logic         sramActivity,
  input  logic         sramWrite,
  input  dpStatus_t    status,
  output ctrlStrobes_t ctrl,
  output logic         sramInhibit,
  output logic         busyDriveLow,
  output logic         eraseOn,
  output logic         progOn,
  output logic         clearOn,
  output logic         xferOn
);

  seqState_e st, nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_OFF;
    else        st <= nxt;
  end

  always_comb begin
    nxt           = st;
    ctrl          = '0;
    ctrl.tmrPhase = PH_ERASE;
    ctrl.cntEn    = (st == S_READY);
    ctrl.writeOk  = (st == S_READY);
    case (st)
      S_OFF: if (pwrGood) begin
        nxt = S_RCL_CLR; ctrl.tmrLoad = 1'b1; ctrl.tmrPhase = PH_CLEAR;
      end
      S_RCL_CLR: if (status.tmrDone) begin
        nxt = S_RCL_XFER; ctrl.tmrLoad = 1'b1; ctrl.tmrPhase = PH_XFER;
      end
      S_RCL_XFER: if (status.tmrDone) nxt = S_READY;
      S_READY: begin
        if (!pwrGood) begin
          nxt = status.dirty ? S_PF_PROBE : S_OFF;
        end else if (swStoreReq) begin
          nxt = S_ST_ERASE; ctrl.tmrLoad = 1'b1; ctrl.tmrPhase = PH_ERASE;
        end else if (swRecallReq) begin
          nxt = S_RCL_CLR; ctrl.tmrLoad = 1'b1; ctrl.tmrPhase = PH_CLEAR;
        end else if (status.hwReq) begin
          if (status.dirty) begin
            nxt = S_HW_WAIT; ctrl.tmrLoad = 1'b1; ctrl.tmrPhase = PH_DELAY;
          end else begin
            nxt = S_HOLD;
          end
        end
      end
      S_HW_WAIT: begin
        if (!pwrGood) begin
          nxt = S_PF_PROBE;
        end else if (sramActivity || sramWrite || status.tmrDone) begin
          nxt = S_ST_ERASE; ctrl.tmrLoad = 1'b1; ctrl.tmrPhase = PH_ERASE;
        end
      end
      S_PF_PROBE: begin
        if (status.lineHigh) begin
          nxt = S_OFF;
        end else begin
          nxt = S_ST_ERASE; ctrl.tmrLoad = 1'b1; ctrl.tmrPhase = PH_ERASE;
        end
      end
      S_ST_ERASE: if (status.tmrDone) begin
        nxt = S_ST_PROG; ctrl.tmrLoad = 1'b1; ctrl.tmrPhase = PH_PROG;
      end
      S_ST_PROG: if (status.tmrDone) begin
        nxt = S_HOLD; ctrl.dirtyClr = 1'b1;
      end
      S_HOLD: begin
        if (!pwrGood)             nxt = S_OFF;
        else if (status.lineHigh) nxt = S_READY;
      end
      default: nxt = S_OFF;
    endcase
  end

  assign sramInhibit  = !((st == S_READY) || (st == S_HW_WAIT));
  assign busyDriveLow = (st == S_PF_PROBE) || (st == S_ST_ERASE) || (st == S_ST_PROG);
  assign eraseOn      = (st == S_ST_ERASE);
  assign progOn       = (st == S_ST_PROG);
  assign clearOn      = (st == S_RCL_CLR);
  assign xferOn       = (st == S_RCL_XFER);

endmodule

// File: rtl/nvseq_ctrl.sv
module nvseq_ctrl
  import nvseq_pkg::*;
#(
  parameter int ERASE_CYC  = 2000,
  parameter int PROG_CYC   = 8000,
  parameter int CLEAR_CYC  = 20,
  parameter int XFER_CYC   = 40,
  parameter int ASSERT_CYC = 50,
  parameter int DELAY_CYC  = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwrGood,
  input  logic swStoreReq,
  input  logic swRecallReq,
  input  logic sramWrite,
  input  logic sramActivity,
  input  logic busyExtLow,
  input  logic busyForceHigh,
  output logic sramInhibit,
  output logic writeAccept,
  output logic busyDriveLow,
  output logic busyLine,
  output logic eraseOn,
  output logic progOn,
  output logic clearOn,
  output logic xferOn
);

  ctrlStrobes_t ctrl;
  dpStatus_t    status;

  nvseq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .pwrGood(pwrGood),
    .swStoreReq(swStoreReq), .swRecallReq(swRecallReq),
    .sramActivity(sramActivity), .sramWrite(sramWrite),
    .status(status), .ctrl(ctrl),
    .sramInhibit(sramInhibit), .busyDriveLow(busyDriveLow),
    .eraseOn(eraseOn), .progOn(progOn), .clearOn(clearOn), .xferOn(xferOn)
  );

  nvseq_dp #(
    .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC), .CLEAR_CYC(CLEAR_CYC),
    .XFER_CYC(XFER_CYC), .ASSERT_CYC(ASSERT_CYC), .DELAY_CYC(DELAY_CYC)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .sramWrite(sramWrite),
    .busyDriveLow(busyDriveLow), .busyExtLow(busyExtLow),
    .busyForceHigh(busyForceHigh), .status(status),
    .writeAccept(writeAccept), .busyLine(busyLine)
  );

endmodule

// File: rtl/nvseq_ctrl_chk.sv
module nvseq_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic sramInhibit,
  input logic writeAccept,
  input logic busyDriveLow,
  input logic busyLine,
  input logic eraseOn,
  input logic progOn,
  input logic clearOn,
  input logic xferOn
);

  p_one_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eraseOn, progOn, clearOn, xferOn}));

  p_store_drives_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (eraseOn || progOn) |-> busyDriveLow);

  p_phase_inhibits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clearOn || xferOn || eraseOn || progOn) |-> sramInhibit);

  p_no_write_when_inhibited_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sramInhibit |-> !writeAccept);

  p_erase_to_prog_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eraseOn) |-> progOn);

  p_clear_to_xfer_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clearOn) |-> xferOn);

  p_abandon_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busyDriveLow) && !eraseOn && busyLine) |=> !busyDriveLow);

endmodule

bind nvseq_ctrl nvseq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sramInhibit(sramInhibit), .writeAccept(writeAccept),
  .busyDriveLow(busyDriveLow), .busyLine(busyLine), .eraseOn(eraseOn),
  .progOn(progOn), .clearOn(clearOn), .xferOn(xferOn)
);

// File: tb/nvseq_ctrl_tb.sv
`timescale 1ns/1ps
module nvseq_ctrl_tb;

  localparam int ERASE_CYC  = 6;
  localparam int PROG_CYC   = 10;
  localparam int CLEAR_CYC  = 3;
  localparam int XFER_CYC   = 4;
  localparam int ASSERT_CYC = 4;
  localparam int DELAY_CYC  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwrGood = 1'b0, swStoreReq = 1'b0, swRecallReq = 1'b0;
  logic sramWrite = 1'b0, sramActivity = 1'b0, busyExtLow = 1'b0, busyForceHigh = 1'b0;
  logic sramInhibit, writeAccept, busyDriveLow, busyLine;
  logic eraseOn, progOn, clearOn, xferOn;

  int checks = 0, failures = 0;
  int cE, cP, cC, cX, cD;

  always #2.5 clk = ~clk;

  nvseq_ctrl #(
    .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC), .CLEAR_CYC(CLEAR_CYC),
    .XFER_CYC(XFER_CYC), .ASSERT_CYC(ASSERT_CYC), .DELAY_CYC(DELAY_CYC)
  ) u_dut (.*);

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clrCounts();
    cE = 0; cP = 0; cC = 0; cX = 0; cD = 0;
  endtask

  task automatic watch(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cE += int'(eraseOn); cP += int'(progOn);
      cC += int'(clearOn); cX += int'(xferOn);
      cD += int'(busyDriveLow);
    end
  endtask

  task automatic doWrite(input string tag);
    sramWrite = 1'b1;
    #1 check({tag, " R11 write accepted in ready"}, int'(writeAccept), 1);
    watch(1);
    sramWrite = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 inhibit in reset", int'(sramInhibit), 1);
    rst_n = 1'b1;
    clrCounts(); watch(3);
    check("R1 inhibit after reset", int'(sramInhibit), 1);
    check("R1 no strobes", cE + cP + cC + cX + cD, 0);
    check("R1 busy line high", int'(busyLine), 1);
  endtask

  task automatic t_powerup();
    clrCounts(); pwrGood = 1'b1; watch(CLEAR_CYC + XFER_CYC + 3);
    check("R2 clear cycles", cC, CLEAR_CYC);
    check("R2 transfer cycles", cX, XFER_CYC);
    check("R2 no store during recall", cE + cP, 0);
    check("R2 enabled after recall", int'(sramInhibit), 0);
  endtask

  task automatic t_sw_store();
    clrCounts(); swStoreReq = 1'b1; watch(1); swStoreReq = 1'b0;
    watch(ERASE_CYC + PROG_CYC + 4);
    check("R3 erase cycles", cE, ERASE_CYC);
    check("R3 program cycles", cP, PROG_CYC);
    check("R3 busy low for whole store", cD, ERASE_CYC + PROG_CYC);
    check("R3 enabled after store", int'(sramInhibit), 0);
  endtask

  task automatic t_sw_recall();
    clrCounts(); swRecallReq = 1'b1; watch(1); swRecallReq = 1'b0;
    watch(CLEAR_CYC + XFER_CYC + 3);
    check("R4 clear cycles", cC, CLEAR_CYC);
    check("R4 transfer cycles", cX, XFER_CYC);
    check("R4 no busy drive", cD, 0);
    check("R4 enabled after recall", int'(sramInhibit), 0);
  endtask

  task automatic t_hw_skip(input string tag);
    clrCounts(); busyExtLow = 1'b1; watch(ASSERT_CYC + 12);
    check({tag, " R5 clean skip: no erase"}, cE + cP, 0);
    check({tag, " R8 locked while line low"}, int'(sramInhibit), 1);
    busyExtLow = 1'b0; watch(1);
    check({tag, " R8 unlocked after line high"}, int'(sramInhibit), 0);
  endtask

  task automatic t_short_pulse();
    doWrite("short");
    clrCounts(); busyExtLow = 1'b1; watch(ASSERT_CYC - 1); busyExtLow = 1'b0;
    watch(DELAY_CYC + 12);
    check("R6 short pulse no store", cE, 0);
    check("R6 short pulse no lock", int'(sramInhibit), 0);
  endtask

  task automatic t_hw_store_timed();
    int pre = 0, inh = 0;
    clrCounts(); busyExtLow = 1'b1;
    for (int i = 0; i < 100; i++) begin
      watch(1);
      if (eraseOn) break;
      pre++; inh += int'(sramInhibit);
    end
    check("R7 cycles before erase", pre, ASSERT_CYC + DELAY_CYC - 1);
    check("R7 SRAM enabled in window", inh, 0);
    watch(ERASE_CYC + PROG_CYC + 4);
    check("R5 dirty hw store erase", cE, ERASE_CYC);
    check("R5 dirty hw store program", cP, PROG_CYC);
    check("R8 locked after store while low", int'(sramInhibit), 1);
    busyExtLow = 1'b0; watch(1);
    check("R8 unlocked after release", int'(sramInhibit), 0);
  endtask

  task automatic t_hw_early();
    doWrite("early");
    clrCounts(); busyExtLow = 1'b1; watch(ASSERT_CYC + 1);
    check("R7 window still enabled", int'(sramInhibit), 0);
    sramActivity = 1'b1; sramWrite = 1'b1;
    #1 check("R7 write in window discarded", int'(writeAccept), 0);
    watch(1);
    sramActivity = 1'b0; sramWrite = 1'b0;
    check("R7 activity starts erase", int'(eraseOn), 1);
    watch(ERASE_CYC + PROG_CYC + 4);
    check("R7 early store erase", cE, ERASE_CYC);
    busyExtLow = 1'b0; watch(1);
  endtask

  task automatic t_power_low_block();
    clrCounts(); pwrGood = 1'b0; watch(2);
    check("R9 inhibit on power loss", int'(sramInhibit), 1);
    check("R9 clean loss no busy drive", cD, 0);
    busyExtLow = 1'b1; watch(ASSERT_CYC + DELAY_CYC + 6);
    check("R9 no store while power low", cE + cP, 0);
    busyExtLow = 1'b0; watch(1);
    clrCounts(); pwrGood = 1'b1; watch(CLEAR_CYC + XFER_CYC + 3);
    check("R9 recall on power return", cC, CLEAR_CYC);
  endtask

  task automatic t_pf_store();
    doWrite("pf");
    clrCounts(); pwrGood = 1'b0; watch(ERASE_CYC + PROG_CYC + 10);
    check("R10 pf store erase", cE, ERASE_CYC);
    check("R10 pf store program", cP, PROG_CYC);
    check("R10 busy drive probe plus store", cD, ERASE_CYC + PROG_CYC + 1);
    check("R10 still inhibited power low", int'(sramInhibit), 1);
    clrCounts(); pwrGood = 1'b1; watch(CLEAR_CYC + XFER_CYC + 3);
    check("R2 recall after brown-out", cX, XFER_CYC);
  endtask

  task automatic t_pf_clean();
    clrCounts(); pwrGood = 1'b0; watch(ERASE_CYC + PROG_CYC + 10);
    check("R5 clean power loss no store", cE + cP, 0);
    check("R5 clean power loss no drive", cD, 0);
    pwrGood = 1'b1; watch(CLEAR_CYC + XFER_CYC + 3);
  endtask

  task automatic t_pf_abandon();
    doWrite("abandon");
    clrCounts(); busyForceHigh = 1'b1; pwrGood = 1'b0;
    watch(ERASE_CYC + PROG_CYC + 10);
    check("R10 abandoned no erase", cE + cP, 0);
    check("R10 single probe cycle", cD, 1);
    check("R10 drive released", int'(busyDriveLow), 0);
    busyForceHigh = 1'b0; pwrGood = 1'b1; watch(CLEAR_CYC + XFER_CYC + 3);
    check("R2 enabled after final recall", int'(sramInhibit), 0);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    t_powerup();
    t_sw_store();
    t_sw_recall();
    t_hw_skip("first");
    t_short_pulse();
    t_hw_store_timed();
    t_hw_early();
    t_hw_skip("after-store");
    t_power_low_block();
    t_pf_store();
    t_pf_clean();
    t_pf_abandon();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule